// File: doc/BRIEF.md
# General-Purpose I/O Port Controller

This block drives one port of up to 32 general-purpose I/O pins and exposes it through a small register interface. The interface carries a valid, a write flag, a byte offset and write data. Three word registers sit on that interface. The level register returns the current pad levels after they pass through a synchronizer. The drive register holds the value placed on each pin. The enable register turns on the output driver of each pin.

A write to the level register is also stored in the drive register. Software can therefore set the outputs through either offset. The parameter `AVAIL_MASK` marks the pins that exist on the port. A clear bit in that mask marks a missing pin. For a missing pin, every register bit reads as 0 and ignores writes, and its pad output and pad enable stay low.

Read data comes back from a register stage one cycle after the request. The pad outputs also come straight from flops.

Top module: `gpio_port`

## Requirements
- R1: After reset the drive and enable registers hold 0, so `pad_oe` and `pad_out` are all 0 and every pin is an input.
- R2: A read of offset 0x0 returns, in bit n, 1 when pad n is high and 0 when it is low. The pad level must have been stable for at least three clock cycles before the read request, because it passes a two-flop synchronizer.
- R3: Offset 0x4 is the drive register. A write stores the data, a read returns it, and `pad_out` bit n equals drive bit n from the cycle after the write.
- R4: A write to offset 0x0 stores its data into the drive register, visible on `pad_out` and through a read of 0x4 from the next cycle.
- R5: Offset 0x8 is the enable register, where 1 means output. `pad_oe` bit n equals enable bit n ANDed with `AVAIL_MASK` bit n from the cycle after the write.
- R6: Register bits of pins whose `AVAIL_MASK` bit is 0 are never modified by writes and always read as 0 in all three registers. The `pad_out` and `pad_oe` bits of those pins stay 0.
- R7: A read of any offset other than 0x0, 0x4 or 0x8 returns 0. A write to such an offset changes no register.
- R8: `rsp_valid` is 1 in exactly the cycle after a read request (`req_valid`=1, `req_write`=0), and `rsp_rdata` carries the data in that cycle.
- R9: While a pin is enabled as an output, offset 0x0 returns the synchronized pad level of that pin, not its drive register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | WIDTH | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | WIDTH | Read data |
| pad_in | input | WIDTH | Asynchronous pad input levels |
| pad_out | output | WIDTH | Pad output levels |
| pad_oe | output | WIDTH | Pad output driver enables |

## Verification
The bench uses an 8-pin port with a sparse availability mask. It sweeps all 256 data patterns through each of three paths: the drive register, the enable register and the level-register write alias. In each case it compares the readback and the pad outputs against the pattern ANDed with the mask. This separates a missing mask, a wrong register and a missing alias.

A sweep of all 256 pad input patterns shows that the synchronized levels arrive at offset 0x0 and do not come from the drive register. A separate case sets opposite drive and pad levels on output-enabled pins to confirm this. Every unmapped offset in the 4-bit address space is written with all ones and then read. Each write must leave the real registers unchanged, and each read must return 0.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_PIN, SEL_OUT, SEL_DIR} reg_sel_e;

  localparam logic [15:0] OFS_PIN = 16'h0000;
  localparam logic [15:0] OFS_OUT = 16'h0004;
  localparam logic [15:0] OFS_DIR = 16'h0008;

  function automatic reg_sel_e decode_ofs(input logic [15:0] ofs);
    case (ofs)
      OFS_PIN: decode_ofs = SEL_PIN;
      OFS_OUT: decode_ofs = SEL_OUT;
      OFS_DIR: decode_ofs = SEL_DIR;
      default: decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int               WIDTH      = 32,
  parameter logic [WIDTH-1:0] AVAIL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] drive_q,
  output logic [WIDTH-1:0] enable_q
);
  logic [WIDTH-1:0] wdata_m;
  assign wdata_m = wdata & AVAIL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q  <= '0;
      enable_q <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PIN, SEL_OUT: drive_q  <= wdata_m;
        SEL_DIR:          enable_q <= wdata_m;
        default:          ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int               WIDTH       = 32,
  parameter int               ADDR_W      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] AVAIL_MASK  = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WIDTH-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [WIDTH-1:0]  rsp_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);
  localparam int OFS_W = 16;

  reg_sel_e         sel;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] pin_sync, drive_q, enable_q, rd_mux;

  assign sel   = decode_ofs(OFS_W'(req_addr));
  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .AVAIL_MASK(AVAIL_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(sel), .wdata(req_wdata),
    .drive_q(drive_q), .enable_q(enable_q)
  );

  always_comb begin
    case (sel)
      SEL_PIN: rd_mux = pin_sync & AVAIL_MASK;
      SEL_OUT: rd_mux = drive_q;
      SEL_DIR: rd_mux = enable_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_mux : '0;
    end
  end

  assign pad_out = drive_q;
  assign pad_oe  = enable_q & AVAIL_MASK;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int               WIDTH      = 32,
  parameter int               ADDR_W     = 4,
  parameter logic [WIDTH-1:0] AVAIL_MASK = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [WIDTH-1:0]  req_wdata,
  input logic              rsp_valid,
  input logic [WIDTH-1:0]  rsp_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe
);
  logic wr_pin, wr_dir, wr_unmapped, rd_req;
  assign rd_req      = req_valid && !req_write;
  assign wr_pin      = req_valid && req_write && (req_addr == ADDR_W'(0));
  assign wr_dir      = req_valid && req_write && (req_addr == ADDR_W'(8));
  assign wr_unmapped = req_valid && req_write && (req_addr != ADDR_W'(0))
                       && (req_addr != ADDR_W'(4)) && (req_addr != ADDR_W'(8));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0));

  // R8
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  // R6
  missing_pins_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe | pad_out | rsp_rdata) & ~AVAIL_MASK) == '0);

  // R4
  pin_write_alias_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pin |=> pad_out == ($past(req_wdata) & AVAIL_MASK));

  // R5
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pad_oe == ($past(req_wdata) & AVAIL_MASK));

  // R7
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_unmapped |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .AVAIL_MASK(AVAIL_MASK)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  localparam int         W  = 8;
  localparam int         AW = 4;
  localparam logic [7:0] M  = 8'hB6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_wdata = '0, pad_in = '0;
  logic          rsp_valid;
  logic [W-1:0]  rsp_rdata, pad_out, pad_oe;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(AW), .SYNC_STAGES(2), .AVAIL_MASK(M)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid", {7'b0, rsp_valid}, 8'h01);
    d = rsp_rdata;
    @(negedge clk);
    check("R8 rsp_valid low after", {7'b0, rsp_valid}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_out", pad_out, 8'h00);
    check("R1 pad_oe", pad_oe, 8'h00);
    rd(4'h4, r); check("R1 drive reg", r, 8'h00);
    rd(4'h8, r); check("R1 enable reg", r, 8'h00);

    // R3 and R6: drive register sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'h4, 8'(v));
      check("R3 pad_out", pad_out, 8'(v) & M);
      rd(4'h4, r);
      check("R6 drive readback", r, 8'(v) & M);
    end

    // R5 and R6: enable register sweep
    for (int v = 0; v < 256; v++) begin
      wr(4'h8, 8'(v));
      check("R5 pad_oe", pad_oe, 8'(v) & M);
      rd(4'h8, r);
      check("R6 enable readback", r, 8'(v) & M);
    end

    // R4: write to the level offset lands in the drive register
    for (int v = 0; v < 256; v++) begin
      wr(4'h0, 8'(v));
      check("R4 pad_out", pad_out, 8'(v) & M);
      rd(4'h4, r);
      check("R4 drive readback", r, 8'(v) & M);
    end

    // R2: pad level sweep with enables off
    wr(4'h8, 8'h00);
    wr(4'h4, 8'h00);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      pad_in = 8'(v);
      repeat (3) @(negedge clk);
      rd(4'h0, r);
      check("R2 level readback", r, 8'(v) & M);
    end

    // R9: outputs enabled, pad level opposite to drive value
    wr(4'h8, 8'hFF);
    wr(4'h4, 8'h00);
    @(negedge clk); pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(4'h0, r); check("R9 level not drive (high)", r, M);
    wr(4'h4, 8'hFF);
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd(4'h0, r); check("R9 level not drive (low)", r, 8'h00);

    // R7: unmapped offsets
    wr(4'h4, 8'h5A);
    wr(4'h8, 8'hC3);
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        wr(4'(a), 8'hFF);
        check("R7 pad_out unchanged", pad_out, 8'h5A & M);
        check("R7 pad_oe unchanged", pad_oe, 8'hC3 & M);
        rd(4'(a), r);
        check("R7 unmapped reads zero", r, 8'h00);
      end
    end
    rd(4'h4, r); check("R7 drive intact", r, 8'h5A & M);
    rd(4'h8, r); check("R7 enable intact", r, 8'hC3 & M);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule